// File: doc/BRIEF.md
# Configuration frame word packer

This block turns the configuration content of one vertical frame into a stream of 32-bit words. Frame content arrives as 18-bit segments, topmost first, over a valid/ready handshake. The block places them back to back, MSB first, inserts the fixed zero fields a memory-content frame needs, and closes every frame with zero bits up to the next 32-bit boundary. The final word of each frame carries a last flag.

Two frame kinds are supported. A logic-column frame has one segment for the top I/O cells, one per logic row, and one for the bottom I/O cells. A memory-content frame opens with an 18-bit zero field and closes with another. In between it carries 72 bits per memory line, delivered as four consecutive segments. The kind is taken from `frame_type_i` with the first segment of each frame. The frame length, and with it the word count, follows from the `ROWS` and `MEM_LINES` parameters.

Top module: `cfg_frame_packer`

## Requirements
- R1: With `frame_type_i`=0 (logic frame) the frame takes exactly ROWS+2 segments and yields ceil(18*(ROWS+2)/32) words. With ROWS=32 that is 612 bits and 20 words.
- R2: Segment bit 17 is the topmost bit and is sent first. The first bit of a frame lands in bit 31 of its first word, and later bits follow in descending bit order without gaps across segments and words.
- R3: With `frame_type_i`=1 (memory frame) the output is 18 zero bits, then MEM_LINES*4 input segments in order, then 18 zero bits. The frame yields ceil((36+72*MEM_LINES)/32) words.
- R4: Every bit between the end of a frame's content and its 32-bit boundary reads as zero.
- R5: `word_last_o` is 1 on the final word of each frame and 0 on every other word.
- R6: While `word_valid_o` is 1 and `word_ready_i` is 0, `word_valid_o` stays 1 and `word_data_o` stays unchanged. Under any backpressure pattern no bit is lost or repeated.
- R7: `frame_type_i` is sampled only when the first segment of a frame is accepted. Changes while later segments of the same frame are accepted have no effect on the output.
- R8: After reset `word_valid_o` is 0 and `seg_ready_o` is 1.
- R9: Once a frame's final segment is accepted, no segment is accepted until that frame's last word has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_type_i | input | 1 | 0 = logic frame, 1 = memory frame; sampled with a frame's first segment |
| seg_valid_i | input | 1 | Segment available |
| seg_ready_o | output | 1 | Segment accepted when high together with valid |
| seg_data_i | input | SEG_W | Segment content, bit SEG_W-1 is topmost |
| word_valid_o | output | 1 | Output word available |
| word_ready_i | input | 1 | Downstream takes the word |
| word_data_o | output | WORD_W | Packed word, MSB first |
| word_last_o | output | 1 | Final word of the frame |

## Verification
Several properties are checked on every cycle:
- A stalled word holds its value and valid.
- The bit count never exceeds the holding buffer.
- The segment index stays within the frame.
- The latched frame kind holds mid-frame.
- The tail of the closing word is zero.

Only the bench's scenarios can show the rest. That covers the exact bit placement across segment and word seams, and the word counts per frame kind. It also covers the zero fields of memory frames and the position of the last flag. The bench compares every word against a bit-level model over many frames with mixed kinds, data patterns, input gaps and output stalls.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;
  typedef enum logic {
    FRM_LOGIC = 1'b0,
    FRM_MEM   = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/cfw_seg_seq.sv
module cfw_seg_seq
  import cfg_frame_pkg::*;
#(
  parameter int ROWS      = 32,
  parameter int MEM_LINES = 8,
  parameter int SEG_W     = 18
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          frame_type_i,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [SEG_W-1:0]              in_seg_i,
  output logic                          push_valid_o,
  input  logic                          push_ready_i,
  output logic [2*SEG_W-1:0]            push_bits_o,
  output logic [$clog2(2*SEG_W+1)-1:0]  push_w_o,
  output logic                          push_last_o
);
  localparam int LOGIC_SEGS = ROWS + 2;
  localparam int MEM_SEGS   = MEM_LINES * 4;
  localparam int MAX_SEGS   = (LOGIC_SEGS > MEM_SEGS) ? LOGIC_SEGS : MEM_SEGS;
  localparam int IDX_W      = $clog2(MAX_SEGS + 1);
  localparam int PW_W       = $clog2(2*SEG_W + 1);
  localparam logic [IDX_W-1:0] LOGIC_LAST = IDX_W'(LOGIC_SEGS - 1);
  localparam logic [IDX_W-1:0] MEM_LAST   = IDX_W'(MEM_SEGS - 1);
  localparam logic [IDX_W-1:0] IDX_MAX    = IDX_W'(MAX_SEGS);
  localparam logic [PW_W-1:0]  W_ONE      = PW_W'(SEG_W);
  localparam logic [PW_W-1:0]  W_TWO      = PW_W'(2*SEG_W);

  logic [IDX_W-1:0] idx_q;
  frame_kind_e      kind_q, kind_cur;
  logic             first, last, accept;

  assign kind_cur = (idx_q == '0) ? frame_kind_e'(frame_type_i) : kind_q;
  assign first    = (idx_q == '0);
  assign last     = (kind_cur == FRM_MEM) ? (idx_q == MEM_LAST) : (idx_q == LOGIC_LAST);
  assign accept   = in_valid_i && push_ready_i;

  assign push_valid_o = in_valid_i;
  assign in_ready_o   = push_ready_i;
  assign push_last_o  = last;

  always_comb begin
    push_bits_o = {in_seg_i, {SEG_W{1'b0}}};
    push_w_o    = W_ONE;
    if (kind_cur == FRM_MEM) begin
      if (first) begin
        push_bits_o = {{SEG_W{1'b0}}, in_seg_i};  // leading zero field
        push_w_o    = W_TWO;
      end else if (last) begin
        push_w_o    = W_TWO;                       // trailing zero field
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      kind_q <= FRM_LOGIC;
    end else if (accept) begin
      idx_q <= last ? '0 : idx_q + 1'b1;
      if (first) kind_q <= frame_kind_e'(frame_type_i);
    end
  end

  p_idx_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_MAX);

  p_kind_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q != '0) |=> (kind_q == $past(kind_q)));
endmodule

// File: rtl/cfw_bit_pack.sv
module cfw_bit_pack #(
  parameter int SEG_W  = 18,
  parameter int WORD_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          push_valid_i,
  output logic                          push_ready_o,
  input  logic [2*SEG_W-1:0]            push_bits_i,
  input  logic [$clog2(2*SEG_W+1)-1:0]  push_w_i,
  input  logic                          push_last_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [WORD_W-1:0]             out_data_o,
  output logic                          out_last_o
);
  localparam int PW    = 2*SEG_W;
  localparam int BUF_W = WORD_W + PW;  // room for a full push below a partial word
  localparam int CNT_W = $clog2(BUF_W + 1);
  localparam logic [CNT_W-1:0] C_WORD  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] C_BUF   = CNT_W'(BUF_W);
  localparam logic [CNT_W-1:0] C_SPACE = CNT_W'(BUF_W - PW);

  logic [BUF_W-1:0] buf_q, buf_base, ins;
  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic             flush_q, pop, push;

  assign out_valid_o = (cnt_q >= C_WORD) || (flush_q && cnt_q != '0);
  assign out_data_o  = buf_q[BUF_W-1 -: WORD_W];
  assign out_last_o  = flush_q && (cnt_q <= C_WORD) && (cnt_q != '0);
  assign pop         = out_valid_o && out_ready_i;

  always_comb begin
    buf_base = buf_q;
    cnt_base = cnt_q;
    if (pop) begin
      buf_base = buf_q << WORD_W;
      cnt_base = (cnt_q > C_WORD) ? cnt_q - C_WORD : '0;
    end
  end

  assign push_ready_o = !flush_q && (cnt_base <= C_SPACE);
  assign push         = push_valid_i && push_ready_o;
  assign ins          = {push_bits_i, {(BUF_W-PW){1'b0}}} >> cnt_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      buf_q <= push ? (buf_base | ins) : buf_base;
      cnt_q <= push ? cnt_base + CNT_W'(push_w_i) : cnt_base;
      if (push && push_last_i)      flush_q <= 1'b1;
      else if (pop && out_last_o)   flush_q <= 1'b0;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= C_BUF);

  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> ((out_data_o << cnt_q) == '0));

  p_hold_input_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && push_last_i) |=> !push_ready_o);
endmodule

// File: rtl/cfg_frame_packer.sv
module cfg_frame_packer #(
  parameter int ROWS      = 32,
  parameter int MEM_LINES = ROWS / 4,
  parameter int SEG_W     = 18,
  parameter int WORD_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_type_i,
  input  logic              seg_valid_i,
  output logic              seg_ready_o,
  input  logic [SEG_W-1:0]  seg_data_i,
  output logic              word_valid_o,
  input  logic              word_ready_i,
  output logic [WORD_W-1:0] word_data_o,
  output logic              word_last_o
);
  localparam int PW_W = $clog2(2*SEG_W + 1);

  logic               push_valid, push_ready, push_last;
  logic [2*SEG_W-1:0] push_bits;
  logic [PW_W-1:0]    push_w;

  cfw_seg_seq #(.ROWS(ROWS), .MEM_LINES(MEM_LINES), .SEG_W(SEG_W)) u_seq (
    .clk_i, .rst_ni, .frame_type_i,
    .in_valid_i   (seg_valid_i),
    .in_ready_o   (seg_ready_o),
    .in_seg_i     (seg_data_i),
    .push_valid_o (push_valid),
    .push_ready_i (push_ready),
    .push_bits_o  (push_bits),
    .push_w_o     (push_w),
    .push_last_o  (push_last)
  );

  cfw_bit_pack #(.SEG_W(SEG_W), .WORD_W(WORD_W)) u_pack (
    .clk_i, .rst_ni,
    .push_valid_i (push_valid),
    .push_ready_o (push_ready),
    .push_bits_i  (push_bits),
    .push_w_i     (push_w),
    .push_last_i  (push_last),
    .out_valid_o  (word_valid_o),
    .out_ready_i  (word_ready_i),
    .out_data_o   (word_data_o),
    .out_last_o   (word_last_o)
  );

  p_reset_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !word_valid_o);
endmodule

// File: tb/cfg_frame_packer_tb.sv
module cfg_frame_packer_tb;
  localparam int ROWS   = 32;
  localparam int ML     = ROWS / 4;
  localparam int SEG_W  = 18;
  localparam int WORD_W = 32;
  localparam int NF     = 40;
  localparam int L_SEGS = ROWS + 2;
  localparam int M_SEGS = ML * 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic frame_type_i = 1'b0, seg_valid_i = 1'b0, word_ready_i = 1'b0;
  logic [SEG_W-1:0] seg_data_i = '0;
  logic seg_ready_o, word_valid_o, word_last_o;
  logic [WORD_W-1:0] word_data_o;

  always #2 clk_i = ~clk_i;

  cfg_frame_packer #(.ROWS(ROWS)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [32:0] exp_q[$];
  int exp_nw[$], exp_pad[$], exp_kind[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit kind_of(input int fi);
    return (fi % 3 == 1) || (fi % 5 == 0);
  endfunction

  function automatic logic [SEG_W-1:0] seg_val(input int fi, input int k);
    logic [31:0] h;
    case (fi % 4)
      0: return '1;
      1: return '0;
      2: return (k % 2 == 0) ? 18'h2AAAA : 18'h15555;
      default: begin
        h = (fi * 37 + k * 113 + 5) * 32'h9E3779B1;
        return h[31:14];
      end
    endcase
  endfunction

  task automatic build(input int fi);
    logic [0:1023] eb;
    int pos, nw, ns;
    bit mem;
    eb  = '0;
    mem = kind_of(fi);
    ns  = mem ? M_SEGS : L_SEGS;
    pos = mem ? SEG_W : 0;
    for (int k = 0; k < ns; k++) begin
      logic [SEG_W-1:0] s;
      s = seg_val(fi, k);
      for (int b = SEG_W - 1; b >= 0; b--) begin
        eb[pos] = s[b];
        pos++;
      end
    end
    if (mem) pos += SEG_W;
    nw = (pos + WORD_W - 1) / WORD_W;
    for (int w = 0; w < nw; w++) exp_q.push_back({(w == nw - 1), eb[w*WORD_W +: WORD_W]});
    exp_nw.push_back(nw);
    exp_pad.push_back(nw * WORD_W - pos);
    exp_kind.push_back(int'(mem));
  endtask

  initial begin
    int f, k, built, cyc, widx, nseg;
    bit acc, prev_stall, done;
    logic [WORD_W-1:0] prev_data;
    logic [15:0] lfsr;
    f = 0; k = 0; built = -1; cyc = 0; widx = 0; acc = 0; prev_stall = 0; done = 0;
    lfsr = 16'hACE1; prev_data = '0;

    #7;
    check(word_valid_o == 1'b0, "R8 valid in reset", 64'(word_valid_o), 0);
    check(seg_ready_o == 1'b1, "R8 ready in reset", 64'(seg_ready_o), 1);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check(word_valid_o == 1'b0, "R8 valid after reset", 64'(word_valid_o), 0);

    while (!done) begin
      @(negedge clk_i);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (acc) begin
        seg_valid_i = 1'b0;
        nseg = kind_of(f) ? M_SEGS : L_SEGS;
        k++;
        if (k == nseg) begin k = 0; f++; end
        acc = 0;
      end
      if (f < NF && !seg_valid_i && (f < 20 || lfsr[7])) begin
        if (k == 0) begin
          if (built != f) begin build(f); built = f; end
          frame_type_i = kind_of(f);
        end else begin
          frame_type_i = lfsr[4];  // R7: noise on non-first segments
        end
        seg_data_i  = seg_val(f, k);
        seg_valid_i = 1'b1;
      end else if (seg_valid_i && k != 0) begin
        frame_type_i = lfsr[9];
      end
      word_ready_i = (f < 10) ? 1'b1 : (f < 30) ? (lfsr[0] | lfsr[3]) : (lfsr[2] & lfsr[5]);
      #1;
      if (prev_stall) begin
        check(word_valid_o == 1'b1, "R6 valid held", 64'(word_valid_o), 1);
        check(word_data_o == prev_data, "R6 data held", 64'(word_data_o), 64'(prev_data));
      end
      prev_stall = word_valid_o && !word_ready_i;
      prev_data  = word_data_o;
      if (word_valid_o && word_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 extra word", 64'(word_data_o), 0);
        end else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          check(word_data_o == e[31:0],
                (exp_kind[0] != 0) ? "R3 R7 memory word" : "R1 R2 R7 logic word",
                64'(word_data_o), 64'(e[31:0]));
          check(word_last_o == e[32], "R5 last flag", 64'(word_last_o), 64'(e[32]));
          widx++;
          if (e[32]) begin
            check(widx == exp_nw[0], "R1 R3 words per frame", 64'(widx), 64'(exp_nw[0]));
            check((word_data_o & ((32'h1 << exp_pad[0]) - 32'h1)) == '0, "R4 zero pad",
                  64'(word_data_o), 64'(word_data_o & ~((32'h1 << exp_pad[0]) - 32'h1)));
            if (exp_kind[0] == 0) check(exp_nw[0] == 20, "R1 20 words at 32 rows", 64'(exp_nw[0]), 20);
            void'(exp_nw.pop_front());
            void'(exp_pad.pop_front());
            void'(exp_kind.pop_front());
            widx = 0;
          end
        end
      end
      if (seg_valid_i && seg_ready_o) begin
        acc = 1;
        nseg = kind_of(f) ? M_SEGS : L_SEGS;
        if (k == nseg - 1) begin
          @(negedge clk_i);
          #1;
          check(seg_ready_o == 1'b0 || exp_q.size() == 0, "R9 input held during close",
                64'(seg_ready_o), 0);
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          seg_valid_i = 1'b0;
          k = 0; f++; acc = 0;
          prev_stall = 1'b0;
          if (word_valid_o && word_ready_i) begin
            logic [32:0] e;
            e = exp_q.pop_front();
            check(word_data_o == e[31:0], "R2 R3 word after close", 64'(word_data_o), 64'(e[31:0]));
            check(word_last_o == e[32], "R5 last flag", 64'(word_last_o), 64'(e[32]));
            widx++;
            if (e[32]) begin
              check(widx == exp_nw[0], "R1 R3 words per frame", 64'(widx), 64'(exp_nw[0]));
              void'(exp_nw.pop_front());
              void'(exp_pad.pop_front());
              void'(exp_kind.pop_front());
              widx = 0;
            end
          end
          prev_stall = word_valid_o && !word_ready_i;
          prev_data  = word_data_o;
        end
      end
      if (f >= NF && exp_q.size() == 0) done = 1;
      if (cyc > 100000) begin
        check(1'b0, "R6 watchdog expired", 64'(cyc), 0);
        done = 1;
      end
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule